// File: doc/BRIEF.md
# ADC Sample Capture and Lane Packer

This block takes 16-bit samples from a parallel converter bus, each sample qualified by a separate strobe line, and packs eight consecutive samples into one 128-bit word. The packed word is offered on an AXI4-Stream master interface that feeds a wide streaming FIFO on its way to a host DMA engine. Packing eight narrow samples into one wide beat means that at 122.88 Msps the stream side needs only one beat every eight sample clocks.

A mode input swaps the converter bus for an internal pattern source. That source is a 16-bit counter that advances by one for every strobed sample and wraps around. With it, the host can confirm that the packing order and the transfer path are gap-free without a live converter attached. A mode change is applied only at a group boundary, so no beat ever mixes the two sources.

If a new group completes while the previous beat is still waiting for the consumer, the new group is dropped and a sticky overflow flag is raised. The flag stays set until a clear input is pulsed.

Top module: `adc_lane_packer`

## Requirements
- R1: A sample is captured, and the lane index advances, only on clock edges where `smp_strobe` is 1. Bus values present while the strobe is 0 never appear in a beat, and seven strobed samples never produce a beat.
- R2: Eight strobed samples form one beat. The earliest sample sits in `m_tdata[15:0]`, and sample k of the group sits in `m_tdata[16k+15:16k]`. `m_tvalid` is 1 right after the clock edge that captures the eighth sample.
- R3: While `m_tvalid` is 1 and `m_tready` is 0, `m_tvalid` stays 1 and `m_tdata` is unchanged. The beat is consumed on the edge where `m_tready` is 1, after which `m_tvalid` is 0 unless a new group completed on that same edge.
- R4: `m_tlast` is 1 and `m_tkeep` is all ones (16 bytes) on every beat.
- R5: With pattern mode active (`pattern_mode` = 1), each sample is the counter value. The counter starts at 0x0000, rises by exactly one per strobed sample and wraps from 0xFFFF to 0x0000. It holds while the converter source is active.
- R6: The source for a whole group is selected by `pattern_mode` as seen at the strobe that fills lane 0. Changes later in the group take effect from the next group.
- R7: If a group completes while a beat is valid and `m_tready` is 0, that group is dropped, the held beat is kept unchanged, and `ovf_flag` becomes 1. The flag then stays 1 until a cycle with `ovf_clear` = 1 and no new overflow.
- R8: Synchronous active-high `rst` clears the lane index, the pending beat (`m_tvalid` = 0), `ovf_flag` and the pattern counter.
- R9: With the strobe high every cycle and `m_tready` held at 1, one beat is produced every eight cycles, no group is dropped and `ovf_flag` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_data | input | 16 | Converter sample bus |
| smp_strobe | input | 1 | Data-valid qualifier for `smp_data` |
| pattern_mode | input | 1 | 1 selects the counter source, 0 selects the converter bus |
| ovf_clear | input | 1 | Clears the sticky overflow flag |
| m_tdata | output | 128 | Packed beat, with the earliest sample in the low lane |
| m_tvalid | output | 1 | Beat valid |
| m_tready | input | 1 | Consumer ready |
| m_tlast | output | 1 | End of packet, 1 on every beat |
| m_tkeep | output | 16 | Byte enables, all ones |
| ovf_flag | output | 1 | Sticky overflow indicator |

## Verification
The packer is driven with groups from the converter bus built from arithmetic runs with distinct steps, including a run whose values wrap through zero. Mismatched steps expose a lane swap or an off-by-one lane, and the wrapping run exposes truncation of the sample values. The same groups are repeated with idle cycles carrying a poison value between strobes, which separates capture on the strobe from capture on every clock. Counter groups are checked against a model of the count, and the count is followed through a full wrap at the maximum strobe rate to show there are neither gaps nor drops. Directed cases cover a mode flip in the middle of a group, an overflow while a beat is held, and a counter cleared by reset.

// File: rtl/adc_pack_pkg.sv
package adc_pack_pkg;
   localparam int unsigned BYTE_BITS = 8;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/adc_pack_pattern.sv
module adc_pack_pattern #(
   parameter int unsigned SAMPLE_W = 16
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                advance,
   output logic [SAMPLE_W-1:0] value
);
   always_ff @(posedge clk) begin
      if (rst)          value <= '0;
      else if (advance) value <= value + 1'b1;
   end
endmodule

// File: rtl/adc_pack_lanes.sv
module adc_pack_lanes #(
   parameter int unsigned SAMPLE_W = 16,
   parameter int unsigned LANES    = 8
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      strobe,
   input  logic [SAMPLE_W-1:0]       din,
   output logic                      at_first,
   output logic                      group_done,
   output logic [SAMPLE_W*LANES-1:0] word
);
   localparam int unsigned IDX_W = $clog2(LANES);
   localparam int unsigned LAST  = LANES - 1;

   logic [IDX_W-1:0] idx;

   always_ff @(posedge clk) begin
      if (rst)         idx <= '0;
      else if (strobe) idx <= idx + 1'b1;
   end

   assign at_first   = (idx == '0);
   assign group_done = strobe && (idx == IDX_W'(LAST));

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      if (k < LAST) begin : g_store
         logic [SAMPLE_W-1:0] held;
         always_ff @(posedge clk) begin
            if (rst)                                held <= '0;
            else if (strobe && idx == IDX_W'(k))    held <= din;
         end
         assign word[k*SAMPLE_W +: SAMPLE_W] = held;
      end else begin : g_pass
         assign word[k*SAMPLE_W +: SAMPLE_W] = din;
      end
   end
endmodule

// File: rtl/adc_pack_beat.sv
module adc_pack_beat #(
   parameter int unsigned WORD_W = 128
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load_req,
   input  logic [WORD_W-1:0] load_word,
   input  logic              ready,
   input  logic              ovf_clear,
   output logic              valid,
   output logic [WORD_W-1:0] data,
   output logic              ovf
);
   logic blocked;
   assign blocked = valid && !ready;

   always_ff @(posedge clk) begin
      if (rst) begin
         valid <= 1'b0;
         data  <= '0;
         ovf   <= 1'b0;
      end else begin
         if (load_req && !blocked) begin
            data  <= load_word;
            valid <= 1'b1;
         end else if (ready) begin
            valid <= 1'b0;
         end
         if (load_req && blocked) ovf <= 1'b1;
         else if (ovf_clear)      ovf <= 1'b0;
      end
   end
endmodule

// File: rtl/adc_lane_packer.sv
module adc_lane_packer #(
   parameter int unsigned SAMPLE_W = 16,
   parameter int unsigned LANES    = 8
) (
   input  logic                                         clk,
   input  logic                                         rst,
   input  logic [SAMPLE_W-1:0]                          smp_data,
   input  logic                                         smp_strobe,
   input  logic                                         pattern_mode,
   input  logic                                         ovf_clear,
   output logic [SAMPLE_W*LANES-1:0]                    m_tdata,
   output logic                                         m_tvalid,
   input  logic                                         m_tready,
   output logic                                         m_tlast,
   output logic [SAMPLE_W*LANES/adc_pack_pkg::BYTE_BITS-1:0] m_tkeep,
   output logic                                         ovf_flag
);
   import adc_pack_pkg::*;

   localparam int unsigned WORD_W = SAMPLE_W * LANES;
   localparam int unsigned KEEP_W = WORD_W / BYTE_BITS;

   if (!is_pow2(LANES) || LANES < 2) begin : g_bad_lanes
      $error("LANES must be a power of two of at least 2");
   end
   if (SAMPLE_W % BYTE_BITS != 0) begin : g_bad_width
      $error("SAMPLE_W must be a whole number of bytes");
   end

   logic                at_first, group_done, group_mode, use_pattern;
   logic [SAMPLE_W-1:0] pat_value, sample;
   logic [WORD_W-1:0]   packed_word;

   // Source choice is frozen at lane 0 for the whole group
   assign use_pattern = at_first ? pattern_mode : group_mode;
   assign sample      = use_pattern ? pat_value : smp_data;

   always_ff @(posedge clk) begin
      if (rst)                        group_mode <= 1'b0;
      else if (smp_strobe && at_first) group_mode <= pattern_mode;
   end

   adc_pack_pattern #(.SAMPLE_W(SAMPLE_W)) u_pattern (
      .clk     (clk),
      .rst     (rst),
      .advance (smp_strobe && use_pattern),
      .value   (pat_value)
   );

   adc_pack_lanes #(.SAMPLE_W(SAMPLE_W), .LANES(LANES)) u_lanes (
      .clk        (clk),
      .rst        (rst),
      .strobe     (smp_strobe),
      .din        (sample),
      .at_first   (at_first),
      .group_done (group_done),
      .word       (packed_word)
   );

   adc_pack_beat #(.WORD_W(WORD_W)) u_beat (
      .clk       (clk),
      .rst       (rst),
      .load_req  (group_done),
      .load_word (packed_word),
      .ready     (m_tready),
      .ovf_clear (ovf_clear),
      .valid     (m_tvalid),
      .data      (m_tdata),
      .ovf       (ovf_flag)
   );

   assign m_tlast = 1'b1;
   assign m_tkeep = {KEEP_W{1'b1}};
endmodule

// File: rtl/adc_lane_packer_chk.sv
module adc_lane_packer_chk #(
   parameter int unsigned WORD_W = 128
) (
   input logic              clk,
   input logic              rst,
   input logic [WORD_W-1:0] m_tdata,
   input logic              m_tvalid,
   input logic              m_tready,
   input logic              m_tlast,
   input logic [WORD_W/8-1:0] m_tkeep,
   input logic              ovf_flag,
   input logic              ovf_clear
);
   // R3
   hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
      (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata)));

   // R4
   beat_framing_chk: assert property (@(posedge clk) disable iff (rst)
      m_tvalid |-> (m_tlast && (&m_tkeep)));

   // R7
   ovf_cause_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(ovf_flag) |-> $past(m_tvalid && !m_tready));

   // R7
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      (ovf_flag && !ovf_clear) |=> ovf_flag);

   // R8
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (!m_tvalid && !ovf_flag));
endmodule

bind adc_lane_packer adc_lane_packer_chk #(.WORD_W(SAMPLE_W*LANES)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .m_tdata   (m_tdata),
   .m_tvalid  (m_tvalid),
   .m_tready  (m_tready),
   .m_tlast   (m_tlast),
   .m_tkeep   (m_tkeep),
   .ovf_flag  (ovf_flag),
   .ovf_clear (ovf_clear)
);

// File: tb/adc_lane_packer_tb.sv
module adc_lane_packer_tb;
   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [15:0]  smp_data = 16'h0;
   logic         smp_strobe = 1'b0;
   logic         pattern_mode = 1'b0;
   logic         ovf_clear = 1'b0;
   logic         m_tready = 1'b0;
   logic [127:0] m_tdata;
   logic         m_tvalid, m_tlast, ovf_flag;
   logic [15:0]  m_tkeep;

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   logic [15:0]  tcnt = 16'h0;
   logic [127:0] exp_word;
   logic         early_valid;

   always #2.5 clk = ~clk;

   adc_lane_packer u_dut (
      .clk(clk), .rst(rst), .smp_data(smp_data), .smp_strobe(smp_strobe),
      .pattern_mode(pattern_mode), .ovf_clear(ovf_clear), .m_tdata(m_tdata),
      .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tlast(m_tlast),
      .m_tkeep(m_tkeep), .ovf_flag(ovf_flag)
   );

   // {gap[33], mode[32], base[31:16], step[15:0]}
   localparam logic [33:0] VEC [6] = '{
      {1'b0, 1'b0, 16'h1234, 16'h1111},
      {1'b1, 1'b0, 16'hFFFC, 16'h0001},
      {1'b0, 1'b1, 16'h0000, 16'h0000},
      {1'b1, 1'b0, 16'hA5A5, 16'h5A5A},
      {1'b1, 1'b1, 16'h0000, 16'h0000},
      {1'b0, 1'b0, 16'h0001, 16'h0100}
   };

   task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic put(input logic [15:0] d, input bit gap);
      smp_data = d; smp_strobe = 1'b1;
      tick();
      smp_strobe = 1'b0; smp_data = 16'hDEAD;
      if (gap) tick();
   endtask

   // Drives one group; mode flips after sw samples (sw=8 means never)
   task automatic fill_group(input bit mode, input logic [15:0] base, input logic [15:0] step,
                             input bit gap, input int sw);
      pattern_mode = mode;
      for (int i = 0; i < 8; i++) begin
         if (i == sw) pattern_mode = ~mode;
         exp_word[16*i +: 16] = mode ? tcnt + 16'(i) : base + 16'(i) * step;
         if (i == 7) early_valid = m_tvalid;
         put(mode ? 16'hBEEF : base + 16'(i) * step, gap);
      end
      if (mode) tcnt = tcnt + 16'd8;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
         end
      end
   end

   initial begin
      tick(); tick(); rst = 1'b0; tick();
      // R8 reset state, R4 framing
      chk(m_tvalid == 1'b0, "R8 tvalid after reset", 128'(m_tvalid), 128'd0);
      chk(ovf_flag == 1'b0, "R8 ovf after reset", 128'(ovf_flag), 128'd0);
      chk(m_tlast && m_tkeep == 16'hFFFF, "R4 tlast/tkeep", {m_tlast, m_tkeep}, {1'b1, 16'hFFFF});

      // Table walk: R1 R2 R3 R4 R5
      foreach (VEC[v]) begin
         fill_group(VEC[v][32], VEC[v][31:16], VEC[v][15:0], VEC[v][33], 8);
         chk(early_valid == 1'b0, "R1 no beat before eighth strobe", 128'(early_valid), 128'd0);
         chk(m_tvalid == 1'b1, "R2 tvalid after eighth strobe", 128'(m_tvalid), 128'd1);
         chk(m_tdata == exp_word, VEC[v][32] ? "R5 pattern lanes" : "R2 lane order", m_tdata, exp_word);
         chk(m_tlast && m_tkeep == 16'hFFFF, "R4 framing on beat", {m_tlast, m_tkeep}, {1'b1, 16'hFFFF});
         tick(); tick();
         chk(m_tvalid && m_tdata == exp_word, "R3 held while not ready", m_tdata, exp_word);
         m_tready = 1'b1; tick(); m_tready = 1'b0;
         chk(m_tvalid == 1'b0, "R3 consumed on ready", 128'(m_tvalid), 128'd0);
      end

      // R6 mode flip mid-group: converter group stays converter
      fill_group(1'b0, 16'h0100, 16'h0003, 1'b0, 3);
      chk(m_tdata == exp_word, "R6 flip to pattern mid-group", m_tdata, exp_word);
      m_tready = 1'b1; tick(); m_tready = 1'b0;
      fill_group(1'b1, 16'h0, 16'h0, 1'b1, 2);
      chk(m_tdata == exp_word, "R6 flip to converter mid-group", m_tdata, exp_word);
      m_tready = 1'b1; tick(); m_tready = 1'b0;
      fill_group(1'b0, 16'h7000, 16'h0002, 1'b0, 8);
      chk(m_tdata == exp_word, "R6 next group uses new mode", m_tdata, exp_word);
      m_tready = 1'b1; tick(); m_tready = 1'b0;

      // R7 overflow
      fill_group(1'b0, 16'h4000, 16'h0010, 1'b0, 8);
      begin
         logic [127:0] first_word;
         first_word = exp_word;
         fill_group(1'b0, 16'h9000, 16'h0020, 1'b0, 8);
         chk(ovf_flag == 1'b1, "R7 overflow raised", 128'(ovf_flag), 128'd1);
         chk(m_tdata == first_word, "R7 held beat kept", m_tdata, first_word);
      end
      m_tready = 1'b1; tick(); m_tready = 1'b0;
      chk(m_tvalid == 1'b0, "R7 dropped group not delivered", 128'(m_tvalid), 128'd0);
      tick(); tick();
      chk(ovf_flag == 1'b1, "R7 flag sticky", 128'(ovf_flag), 128'd1);
      ovf_clear = 1'b1; tick(); ovf_clear = 1'b0;
      chk(ovf_flag == 1'b0, "R7 flag cleared", 128'(ovf_flag), 128'd0);

      // R5 / R9 full-rate wrap
      rst = 1'b1; tick(); rst = 1'b0; tcnt = 16'h0;
      m_tready = 1'b1; pattern_mode = 1'b1;
      smp_strobe = 1'b1;
      for (int i = 0; i < 65528; i++) tick();
      smp_strobe = 1'b0;
      tcnt = 16'hFFF8;
      fill_group(1'b1, 16'h0, 16'h0, 1'b0, 8);
      chk(m_tvalid && m_tdata == exp_word, "R5 top of count", m_tdata, exp_word);
      fill_group(1'b1, 16'h0, 16'h0, 1'b0, 8);
      chk(m_tvalid && m_tdata == exp_word, "R5 wrap to zero", m_tdata, exp_word);
      chk(ovf_flag == 1'b0, "R9 no drop at full rate", 128'(ovf_flag), 128'd0);
      tick();
      chk(m_tvalid == 1'b0, "R9 single beat per group", 128'(m_tvalid), 128'd0);

      // R8 reset clears counter
      rst = 1'b1; tick(); rst = 1'b0; tcnt = 16'h0;
      fill_group(1'b1, 16'h0, 16'h0, 1'b0, 8);
      chk(m_tdata == exp_word, "R8 counter restarts at zero", m_tdata, exp_word);
      m_tready = 1'b0;

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule